// File: doc/BRIEF.md
# Modulus Down-Counter with Reload

This block is a 16-bit down-counter that a register bus programs and reads. A free-running prescaler divides the module clock by 1, 4, 8 or 16 to form a decrement enable. The counter runs in one of two modes.

- **Single-run:** it counts down from a loaded value and stops at zero.
- **Reload:** each time it reaches zero, it reloads from the value most recently written to the count register.

Reaching zero sets a sticky underflow flag, and an interrupt follows that flag when it is enabled. A read-select bit chooses what reads of the count register return: the live count or the stored load value.

The sequencing is a four-state machine.

**States:**
- `ST_OFF`: counter disabled, count preset to 0xFFFF.
- `ST_LOAD`: waiting for a tick to copy the load value into the count.
- `ST_RUN`: decrementing once per tick.
- `ST_HALT`: single-run mode, stopped at zero.

**Transitions:**
- any → `ST_OFF` when the enable bit is 0.
- `ST_OFF` → `ST_LOAD` when the enable bit is 1.
- `ST_LOAD` → `ST_RUN` on a tick that loads a non-zero value.
- `ST_LOAD` → `ST_HALT` (single-run) or `ST_LOAD` (reload) on a tick that loads zero.
- `ST_RUN` → `ST_HALT` (single-run) or `ST_LOAD` (reload) on the tick that takes the count from 1 to 0.
- `ST_HALT` → `ST_LOAD` on a write to the count register.

**Register map** (`bus_addr`):

| Address | Register | Fields |
|---|---|---|
| 0 | Control | bit 7 interrupt enable, bit 6 reload mode, bit 5 read-select, bits 4 and 3 write-only strobes, bit 2 enable, bits 1:0 prescaler select |
| 1 | Count/load | read: live count or load value; write: load value |
| 2 | Flag | bit 0 underflow flag |

Address 3 reads zero. Reads are combinational on `bus_addr`. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high.

Top module: `moddown_timer`

## Requirements
- R1: After reset, the control register reads 0x00, address 1 reads 0xFFFF, the flag reads 0 and `irq` is 0.
- R2: Control bits 7, 6, 5, 2 and 1:0 read back as written. Bits 4 and 3 always read 0.
- R3: Prescaler select 0, 1, 2 and 3 gives one decrement tick every 1, 4, 8 or 16 clocks. With the enable set at edge E0, ticks fall on edges E(n·d), and the first one used is the earliest at or after E2.
- R4: On the first used tick after enabling, the count takes the load value. Each later tick lowers it by exactly one.
- R5: In single-run mode (bit 6 = 0), the count stops at 0x0000 and stays there.
- R6: In reload mode (bit 6 = 1), the tick after the count reaches 0 loads the value most recently written to address 1, even when that write came while counting.
- R7: When the enable bit is 0, the count becomes 0xFFFF on the next clock edge and stays there.
- R8: Address 1 reads the live count when bit 5 = 0 and the load value when bit 5 = 1.
- R9: Reaching zero sets the flag (address 2 bit 0). It stays set until a write to address 2 with bit 0 = 1, and a write with bit 0 = 0 leaves it set.
- R10: `irq` is high exactly when the flag is set and bit 7 is 1.
- R11: A write to address 1 while the counter is stopped at zero in single-run mode loads the written value on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational on `bus_addr` |
| irq | output | 1 | Underflow interrupt |

## Verification
The assertions assume the bus inputs settle between clock edges, and that a change of prescaler select is rare enough that a tick followed by a select change is the only case the tick-spacing check must allow for. The stimulus drives every bus signal on the falling edge. It changes mode and prescaler only while the counter is disabled, as software is expected to do, and keeps load values small so that each run reaches zero and reloads more than once within its window.

// File: rtl/moddown_pkg.sv
package moddown_pkg;

    // control register bit positions
    localparam int B_IRQ_EN  = 7;
    localparam int B_MOD     = 6;
    localparam int B_RD_LOAD = 5;
    localparam int B_EN      = 2;
    localparam int B_PSEL_HI = 1;
    localparam int B_PSEL_LO = 0;

    // register addresses
    localparam logic [1:0] A_CTRL  = 2'd0;
    localparam logic [1:0] A_COUNT = 2'd1;
    localparam logic [1:0] A_FLAG  = 2'd2;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_LOAD,
        ST_RUN,
        ST_HALT
    } cnt_state_t;

    typedef struct packed {
        logic       irq_en;
        logic       mod_en;
        logic       rd_load;
        logic       en;
        logic [1:0] psel;
    } ctrl_t;

    // divide ratio for a prescaler select code: 1, 4, 8, 16
    function automatic int unsigned div_of(input logic [1:0] s);
        if (s == 2'd0) return 1;
        return 32'd1 << (int'(s) + 1);
    endfunction

endpackage

// File: rtl/moddown_prescale.sv
module moddown_prescale
    import moddown_pkg::*;
#(
    parameter int PRE_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] psel,
    output logic       tick
);

    logic [PRE_W-1:0] pcnt;
    logic [PRE_W-1:0] lim;

    always_comb begin
        lim  = PRE_W'(div_of(psel) - 1);
        tick = run && (pcnt >= lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (!run || tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    // R3: with a divider above one, two ticks never fall on adjacent cycles
    a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && psel != 2'd0) |=> (!tick || psel == 2'd0));

endmodule

// File: rtl/moddown_regs.sv
module moddown_regs
    import moddown_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             set_flag,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] load_val,
    output logic             wr_count,
    output logic             flag,
    output logic [CNT_W-1:0] bus_rdata
);

    logic wr_any;
    logic wr_ctrl;
    logic wr_flag;

    always_comb begin
        wr_any   = bus_sel && bus_wr;
        wr_ctrl  = wr_any && (bus_addr == A_CTRL);
        wr_count = wr_any && (bus_addr == A_COUNT);
        wr_flag  = wr_any && (bus_addr == A_FLAG);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl.irq_en  <= bus_wdata[B_IRQ_EN];
            ctrl.mod_en  <= bus_wdata[B_MOD];
            ctrl.rd_load <= bus_wdata[B_RD_LOAD];
            ctrl.en      <= bus_wdata[B_EN];
            ctrl.psel    <= bus_wdata[B_PSEL_HI:B_PSEL_LO];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_val <= '0;
        end else if (wr_count) begin
            load_val <= bus_wdata;
        end
    end

    // setting has priority over a clearing write in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_flag) begin
            flag <= 1'b1;
        end else if (wr_flag && bus_wdata[0]) begin
            flag <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[B_IRQ_EN]  = ctrl.irq_en;
                bus_rdata[B_MOD]     = ctrl.mod_en;
                bus_rdata[B_RD_LOAD] = ctrl.rd_load;
                bus_rdata[B_EN]      = ctrl.en;
                bus_rdata[B_PSEL_HI:B_PSEL_LO] = ctrl.psel;
            end
            A_COUNT: bus_rdata = ctrl.rd_load ? load_val : cnt_val;
            A_FLAG:  bus_rdata[0] = flag;
            default: bus_rdata = '0;
        endcase
    end

    // R9: the flag stays set unless a write of 1 to the flag address clears it
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr_flag && bus_wdata[0])) |=> flag);

    // R9: a zero event from the counter always lands in the flag
    a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_flag |=> flag);

endmodule

// File: rtl/moddown_core.sv
module moddown_core
    import moddown_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             mod_en,
    input  logic             tick,
    input  logic             wr_count,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             set_flag
);

    cnt_state_t       st, st_n;
    logic [CNT_W-1:0] cnt_n;
    logic [CNT_W-1:0] src;

    // a write in the loading cycle supplies the newest value directly
    always_comb begin
        src = wr_count ? wr_data : load_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_OFF;
            cnt <= '1;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        st_n     = st;
        cnt_n    = cnt;
        set_flag = 1'b0;
        if (!en) begin
            st_n  = ST_OFF;
            cnt_n = '1;
        end else begin
            unique case (st)
                ST_OFF: begin
                    st_n = ST_LOAD;
                end
                ST_LOAD: begin
                    if (tick) begin
                        cnt_n = src;
                        if (src == '0) begin
                            set_flag = 1'b1;
                            st_n     = mod_en ? ST_LOAD : ST_HALT;
                        end else begin
                            st_n = ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (tick) begin
                        cnt_n = cnt - 1'b1;
                        if (cnt == CNT_W'(1)) begin
                            set_flag = 1'b1;
                            st_n     = mod_en ? ST_LOAD : ST_HALT;
                        end
                    end
                end
                ST_HALT: begin
                    if (wr_count) st_n = ST_LOAD;
                end
            endcase
        end
    end

    // R7: a cleared enable presets the count on the next edge
    a_r7_off_preset: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> cnt == '1);

    // R4: a running tick lowers the count by exactly one
    a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && en && tick) |=> cnt == CNT_W'($past(cnt) - 1'b1));

    // R6: a loading tick takes the newest written value
    a_r6_reload_src: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOAD && en && tick) |=> cnt == $past(src));

    // R5: a halted single-run counter holds zero
    a_r5_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HALT && en && !wr_count) |=> cnt == '0);

    // R11: a write while halted arms a load
    a_r11_halt_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HALT && en && wr_count) |=> st == ST_LOAD);

endmodule

// File: rtl/moddown_timer.sv
module moddown_timer
    import moddown_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt;
    logic             wr_count;
    logic             flag;
    logic             set_flag;
    logic             tick;

    moddown_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_val   (cnt),
        .set_flag  (set_flag),
        .ctrl      (ctrl),
        .load_val  (load_val),
        .wr_count  (wr_count),
        .flag      (flag),
        .bus_rdata (bus_rdata)
    );

    moddown_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl.en),
        .psel  (ctrl.psel),
        .tick  (tick)
    );

    moddown_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctrl.en),
        .mod_en   (ctrl.mod_en),
        .tick     (tick),
        .wr_count (wr_count),
        .wr_data  (bus_wdata),
        .load_val (load_val),
        .cnt      (cnt),
        .set_flag (set_flag)
    );

    always_comb begin
        irq = flag && ctrl.irq_en;
    end

endmodule

// File: tb/moddown_timer_bench.sv
module moddown_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    moddown_timer u_moddown_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    function automatic int div_for(input int s);
        return (s == 0) ? 1 : (1 << (s + 1));
    endfunction

    function automatic int first_tick(input int d);
        return (d == 1) ? 2 : d;
    endfunction

    // expected count k edges after the enabling edge (R3, R4, R5, R6)
    function automatic logic [15:0] exp_cnt(input int l, input int d, input int k, input bit m);
        int f, j;
        f = first_tick(d);
        if (k < f) return 16'hFFFF;
        j = (k - f) / d;
        if (!m) return (j >= l) ? 16'd0 : 16'(l - j);
        return 16'(l - (j % (l + 1)));
    endfunction

    function automatic logic exp_flag(input int l, input int d, input int k);
        int f;
        f = first_tick(d);
        return (k >= f) && (((k - f) / d) >= l);
    endfunction

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%h expected=%h", 16'd1, 16'd0);
        finish_run();
    end

    initial begin
        logic [15:0] v;
        int seen;
        void'($urandom(32'd20250611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        rd(2'd0, v); chk("R1 ctrl", v, 16'h0000);
        rd(2'd1, v); chk("R1 count", v, 16'hFFFF);
        rd(2'd2, v); chk("R1 flag", v, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'd0);

        // R2: strobe bits read 0, others read back
        bus_write(2'd0, 16'h00DB);
        rd(2'd0, v); chk("R2 ctrl readback", v, 16'h00C3);
        bus_write(2'd0, 16'h0000);

        // R3 R4 R5 R6 R9 R10: random runs checked every cycle
        for (int it = 0; it < 20; it++) begin
            int l, s, d, kmax;
            bit m;
            l = int'($urandom_range(30, 0));
            s = int'($urandom_range(3, 0));
            m = bit'($urandom_range(1, 0));
            if (it == 0) begin l = 0; s = 0; m = 1'b0; end
            if (it == 1) begin l = 1; s = 0; m = 1'b1; end
            d = div_for(s);
            kmax = first_tick(d) + d * (2 * l + 4);
            bus_write(2'd0, 16'h0000);
            bus_write(2'd1, 16'(l));
            bus_write(2'd2, 16'h0001);
            bus_write(2'd0, 16'h0084 | (16'(m) << 6) | 16'(s));
            bus_addr = 2'd1;
            for (int k = 1; k <= kmax; k++) begin
                @(negedge clk);
                #1;
                chk(m ? "R6 count" : "R5 count", bus_rdata, exp_cnt(l, d, k, m));
                chk("R10 irq", {15'd0, irq}, {15'd0, exp_flag(l, d, k)});
            end
        end

        // R7 and R8: disabled preset and read-select
        bus_write(2'd0, 16'h0000);
        @(negedge clk);
        rd(2'd1, v); chk("R7 preset", v, 16'hFFFF);
        bus_write(2'd1, 16'h1234);
        bus_write(2'd0, 16'h0020);
        rd(2'd1, v); chk("R8 load view", v, 16'h1234);
        bus_write(2'd0, 16'h0000);
        rd(2'd1, v); chk("R8 live view", v, 16'hFFFF);

        // R9 R10 R5: single-run to zero with interrupt disabled
        bus_write(2'd2, 16'h0001);
        bus_write(2'd1, 16'h0002);
        bus_write(2'd0, 16'h0004);
        repeat (6) @(negedge clk);
        rd(2'd1, v); chk("R5 stopped", v, 16'h0000);
        rd(2'd2, v); chk("R9 flag set", v, 16'h0001);
        chk("R10 gated", {15'd0, irq}, 16'd0);
        bus_write(2'd2, 16'h0000);
        rd(2'd2, v); chk("R9 write 0 ignored", v, 16'h0001);
        bus_write(2'd2, 16'h0001);
        rd(2'd2, v); chk("R9 cleared", v, 16'h0000);

        // R11: write while halted loads on next tick
        bus_write(2'd1, 16'h0005);
        bus_addr = 2'd1;
        @(negedge clk); #1;
        chk("R11 loaded", bus_rdata, 16'h0005);
        @(negedge clk); #1;
        chk("R11 counting", bus_rdata, 16'h0004);

        // R6: write during a reload run takes effect at the next reload
        bus_write(2'd0, 16'h0000);
        bus_write(2'd1, 16'h0003);
        bus_write(2'd0, 16'h0044);
        bus_write(2'd1, 16'h0006);
        bus_addr = 2'd1;
        seen = 0;
        for (int k = 0; k < 40 && seen == 0; k++) begin
            @(negedge clk); #1;
            if (bus_rdata == 16'h0000) seen = 1;
        end
        chk("R6 reached zero", 16'(seen), 16'd1);
        @(negedge clk); #1;
        chk("R6 latest value", bus_rdata, 16'h0006);

        // R7: disable while running
        bus_write(2'd0, 16'h0000);
        @(negedge clk);
        rd(2'd1, v); chk("R7 running preset", v, 16'hFFFF);

        finish_run();
    end

endmodule